// File: doc/BRIEF.md
# Redundant Settings Record Selector

This block recovers a user-settings record from a byte-wide configuration memory that holds two redundant copies of it. After a one-cycle start pulse it reads a 16-bit pointer, turns it into a base address, rejects a base that lies past the upper limit, and then scans both copies. For each copy it computes a CRC-16 over the payload and compares it with the checksum stored after a 16-bit generation count. It picks one copy by validity and generation, streams that copy's payload out one byte per valid strobe, and ends with a one-cycle done pulse that carries a good/bad flag.

The memory port is a plain synchronous read port. The block drives `mem_rd` and `mem_addr` in one cycle and takes `mem_rdata` in the next. Addresses are issued back to back, so each read is pipelined against the consumption of the previous byte. The control is a single state machine with seven states. IDLE waits for start. PTR reads the two pointer bytes. BOUND checks the base. SCAN reads copy 0 and then copy 1. PICK chooses a copy. EMIT streams the payload. DONE raises done for one cycle.

The transitions are as follows. IDLE goes to PTR on start. PTR goes to BOUND once the high pointer byte arrives. BOUND goes to DONE (failure) when the base is out of range, and to SCAN otherwise. SCAN goes to PICK after the last byte of copy 1. PICK goes to EMIT when some copy is valid, and to DONE (failure) when none is. EMIT goes to DONE (success) after the last payload byte. DONE always returns to IDLE.

Top module: `settings_copy_picker`

## Requirements
- R1: The record base is the 16-bit little-endian pointer read from byte addresses 0x20 (low byte) and 0x21 (high byte), multiplied by 8.
- R2: When the base exceeds 0x3FE00, done rises with done_ok low, no byte is streamed, and only the two pointer reads take place. A base equal to 0x3FE00 is accepted.
- R3: Copy 0 starts at the base, and copy 1 starts 0x100 bytes above it.
- R4: A copy's CRC starts at 0xFFFF and covers its first 0x70 bytes. Each byte is XORed into the low 8 bits of the CRC. Then, for each of 8 steps j = 0..7, the CRC is shifted right by one, and when the bit shifted out was 1, tap[j] shifted left by (7-j) is XORed in. The taps are 0xC0C1, 0xC181, 0xC301, 0xC601, 0xCC01, 0xD801, 0xF001, 0xA001 for j = 0..7.
- R5: Within a copy, the generation count is little-endian at offsets 0x70/0x71 and the stored CRC is little-endian at 0x72/0x73. A copy is valid when the stored CRC equals the computed CRC.
- R6: When both copies are valid, copy 1 is chosen only if its count is strictly greater as an unsigned number. On equal counts copy 0 is chosen.
- R7: When exactly one copy is valid, that copy is chosen. When neither is valid, done rises with done_ok low and no byte is streamed.
- R8: On success, exactly 0x70 bytes of the chosen copy are streamed on out_data with out_valid high, in ascending address order starting from the copy's first byte, and done_ok is high with the done pulse.
- R9: done is high for exactly one cycle per accepted start. A start that arrives while busy is high is ignored.
- R10: After reset the block is idle: busy, done, mem_rd and out_valid are low. A successful run makes 2 + 2×0x74 + 0x70 reads, and a run with no valid copy makes 2 + 2×0x74 reads. Read data is taken from mem_rdata in the cycle after mem_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the selection |
| busy | output | 1 | High from an accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | With done: high when a record was streamed |
| mem_rd | output | 1 | Read request to the configuration memory |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| out_valid | output | 1 | Payload byte strobe |
| out_data | output | 8 | Payload byte |

## Verification
The bench sweeps every combination of copy validity against generation counts of 0, 1, 0x7FFF and 0xFFFF. This catches a design that compares counts as signed numbers, prefers copy 1 on a tie, or ignores validity and streams a corrupt copy. A corrupt copy is made by flipping a bit in the high byte of the stored CRC, so a design that compares only the low byte is caught. The bench tries pointers just at and just past the base limit. A design with an off-by-one limit would stream from out of range or refuse a legal base, and one that reads the records before checking the bound shows extra reads. A second start is sent in the middle of a run, which exposes a controller that restarts and produces a second done pulse or a truncated stream.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PTR,
        ST_BOUND,
        ST_SCAN,
        ST_PICK,
        ST_EMIT,
        ST_DONE
    } scp_state_e;

    function automatic logic [15:0] crc_tap(input int j);
        logic [15:0] t;
        unique case (j)
            0:       t = 16'hC0C1;
            1:       t = 16'hC181;
            2:       t = 16'hC301;
            3:       t = 16'hC601;
            4:       t = 16'hCC01;
            5:       t = 16'hD801;
            6:       t = 16'hF001;
            default: t = 16'hA001;
        endcase
        return t;
    endfunction

    // One byte of the LSB-first CRC. Each tap lands back inside 16 bits
    // by the end of the byte, so a 24-bit working value suffices.
    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] d);
        logic [23:0] acc;
        logic        fb;
        acc = {8'h00, c ^ {8'h00, d}};
        for (int j = 0; j < 8; j++) begin
            fb  = acc[0];
            acc = acc >> 1;
            if (fb) begin
                acc = acc ^ ({8'h00, crc_tap(j)} << (7 - j));
            end
        end
        return acc[15:0];
    endfunction

endpackage

// File: rtl/scp_crc16.sv
module scp_crc16 #(
    parameter logic [15:0] SEED = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    import scp_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= SEED;
        end else if (clr) begin
            crc <= SEED;
        end else if (en) begin
            crc <= crc_byte(crc, din);
        end
    end

endmodule

// File: rtl/scp_arbiter.sv
module scp_arbiter #(
    parameter int CNT_W = 16
) (
    input  logic             ok_a,
    input  logic             ok_b,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    output logic             any_ok,
    output logic             take_b
);
    always_comb begin
        any_ok = ok_a | ok_b;
        take_b = ok_b & (~ok_a | (cnt_b > cnt_a));
    end

endmodule

// File: rtl/settings_copy_picker.sv
module settings_copy_picker #(
    parameter int ADDR_W      = 18,
    parameter int PTR_ADDR    = 'h20,
    parameter int PTR_SHIFT   = 3,
    parameter int BASE_LIMIT  = 'h3FE00,
    parameter int COPY_STRIDE = 'h100,
    parameter int PAY_LEN     = 'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              done_ok,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data
);
    import scp_pkg::*;

    localparam int CNT_OFF  = PAY_LEN;
    localparam int CRC_OFF  = PAY_LEN + 2;
    localparam int REC_SPAN = PAY_LEN + 4;
    localparam int IDX_W    = $clog2(REC_SPAN + 1);
    localparam int BASE_W   = 16 + PTR_SHIFT;

    localparam logic [IDX_W-1:0] LIM_PTR    = IDX_W'(2);
    localparam logic [IDX_W-1:0] LIM_SPAN   = IDX_W'(REC_SPAN);
    localparam logic [IDX_W-1:0] LIM_PAY    = IDX_W'(PAY_LEN);
    localparam logic [IDX_W-1:0] I_PTR_HI   = IDX_W'(1);
    localparam logic [IDX_W-1:0] I_CNT_LO   = IDX_W'(CNT_OFF);
    localparam logic [IDX_W-1:0] I_CNT_HI   = IDX_W'(CNT_OFF + 1);
    localparam logic [IDX_W-1:0] I_CRC_LO   = IDX_W'(CRC_OFF);
    localparam logic [IDX_W-1:0] I_CRC_HI   = IDX_W'(CRC_OFF + 1);
    localparam logic [IDX_W-1:0] I_PAY_LAST = IDX_W'(PAY_LEN - 1);

    scp_state_e         state, state_nx;
    logic [IDX_W-1:0]   iss;
    logic               pend;
    logic [IDX_W-1:0]   pend_idx;
    logic [7:0]         ptr_lo;
    logic [BASE_W-1:0]  base_q;
    logic               copy_q;
    logic [7:0]         cnt_lo;
    logic [7:0]         sum_lo;
    logic [1:0]         ok_v;
    logic [1:0][15:0]   cnt_v;
    logic               ok_q;
    logic [IDX_W-1:0]   lim;
    logic               base_bad;
    logic               scan_last;
    logic               crc_clr, crc_en;
    logic [15:0]        crc_val;
    logic               any_ok, take_b;
    logic [ADDR_W-1:0]  rec_base;

    assign base_bad  = 32'(base_q) > 32'(BASE_LIMIT);
    assign scan_last = (state == ST_SCAN) && pend && (pend_idx == I_CRC_HI);
    assign crc_clr   = (state == ST_BOUND) || (scan_last && !copy_q);
    assign crc_en    = (state == ST_SCAN) && pend && (pend_idx < LIM_PAY);

    scp_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (mem_rdata),
        .crc   (crc_val)
    );

    scp_arbiter #(.CNT_W(16)) u_arb (
        .ok_a   (ok_v[0]),
        .ok_b   (ok_v[1]),
        .cnt_a  (cnt_v[0]),
        .cnt_b  (cnt_v[1]),
        .any_ok (any_ok),
        .take_b (take_b)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_PTR;
            ST_PTR:   if (pend && pend_idx == I_PTR_HI) state_nx = ST_BOUND;
            ST_BOUND: state_nx = base_bad ? ST_DONE : ST_SCAN;
            ST_SCAN:  if (scan_last && copy_q) state_nx = ST_PICK;
            ST_PICK:  state_nx = any_ok ? ST_EMIT : ST_DONE;
            ST_EMIT:  if (pend && pend_idx == I_PAY_LAST) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs and read port
    always_comb begin
        rec_base = ADDR_W'(base_q) + (copy_q ? ADDR_W'(COPY_STRIDE) : '0);
        unique case (state)
            ST_PTR:  lim = LIM_PTR;
            ST_SCAN: lim = LIM_SPAN;
            ST_EMIT: lim = LIM_PAY;
            default: lim = '0;
        endcase
        mem_rd = iss < lim;
        unique case (state)
            ST_PTR:             mem_addr = ADDR_W'(PTR_ADDR) + ADDR_W'(iss);
            ST_SCAN, ST_EMIT:   mem_addr = rec_base + ADDR_W'(iss);
            default:            mem_addr = '0;
        endcase
        busy    = state != ST_IDLE;
        done    = state == ST_DONE;
        done_ok = (state == ST_DONE) && ok_q;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iss       <= '0;
            pend      <= 1'b0;
            pend_idx  <= '0;
            ptr_lo    <= '0;
            base_q    <= '0;
            copy_q    <= 1'b0;
            cnt_lo    <= '0;
            sum_lo    <= '0;
            ok_v      <= '0;
            cnt_v     <= '0;
            ok_q      <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            pend      <= mem_rd;
            pend_idx  <= iss;
            out_valid <= 1'b0;
            if (mem_rd) iss <= iss + IDX_W'(1);
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        iss    <= '0;
                        ok_q   <= 1'b0;
                        copy_q <= 1'b0;
                    end
                end
                ST_PTR: begin
                    if (pend) begin
                        if (pend_idx == I_PTR_HI)
                            base_q <= BASE_W'({mem_rdata, ptr_lo}) << PTR_SHIFT;
                        else
                            ptr_lo <= mem_rdata;
                    end
                end
                ST_BOUND: begin
                    iss    <= '0;
                    copy_q <= 1'b0;
                    ok_v   <= '0;
                end
                ST_SCAN: begin
                    if (pend) begin
                        if (pend_idx == I_CNT_LO) cnt_lo <= mem_rdata;
                        if (pend_idx == I_CNT_HI) cnt_v[copy_q] <= {mem_rdata, cnt_lo};
                        if (pend_idx == I_CRC_LO) sum_lo <= mem_rdata;
                        if (pend_idx == I_CRC_HI) begin
                            ok_v[copy_q] <= (crc_val == {mem_rdata, sum_lo});
                            if (!copy_q) begin
                                copy_q <= 1'b1;
                                iss    <= '0;
                            end
                        end
                    end
                end
                ST_PICK: begin
                    copy_q <= take_b;
                    iss    <= '0;
                end
                ST_EMIT: begin
                    if (pend) begin
                        out_valid <= 1'b1;
                        out_data  <= mem_rdata;
                        if (pend_idx == I_PAY_LAST) ok_q <= 1'b1;
                    end
                end
                ST_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a start while busy does not restart the pointer fetch
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && start) |=> !(state == ST_PTR && iss == '0));

    // R2: records are only scanned below the limit
    a_r2_bound_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN) |-> (32'(base_q) <= 32'(BASE_LIMIT)));

    // R8: copy-out addresses rise by one
    a_r8_emit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && mem_rd && $past(state == ST_EMIT && mem_rd))
            |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

    // R8: bytes appear only during copy-out
    a_r8_out_window: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (state == ST_EMIT || state == ST_DONE));

    // R7: a failed run streams nothing at its end
    a_r7_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> !out_valid);

    // R6: tie or smaller count keeps copy 0
    a_r6_tie_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PICK && ok_v == 2'b11 && cnt_v[1] <= cnt_v[0]) |=> !copy_q);

    // R10: idle means no reads and no output
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!mem_rd && !out_valid));

endmodule

// File: tb/settings_copy_picker_tb.sv
module settings_copy_picker_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PAY        = 'h70;
    localparam int RD_OK      = 2 + 2 * 'h74 + 'h70;
    localparam int RD_NONE    = 2 + 2 * 'h74;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        busy, done, done_ok, mem_rd, out_valid;
    logic [17:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  out_data;

    logic [7:0]  win [0:511];
    logic [15:0] ptr_v = 16'h0;
    int          tb_base = 0;
    logic [7:0]  got [0:255];
    int          nout, ndone, nrd;
    bit          last_ok;
    int          checks = 0, failures = 0;

    settings_copy_picker u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .done_ok   (done_ok),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] mem_fn(input int a);
        if (a == 'h20) return ptr_v[7:0];
        if (a == 'h21) return ptr_v[15:8];
        if (a >= tb_base && a < tb_base + 512) return win[a - tb_base];
        return 8'hEE;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem_fn(int'(mem_addr));
            nrd = nrd + 1;
        end
    end

    always @(negedge clk) begin
        if (out_valid) begin
            if (nout < 256) got[nout] = out_data;
            nout = nout + 1;
        end
        if (done) begin
            ndone = ndone + 1;
            last_ok = done_ok;
        end
    end

    task automatic chk(input bit cond, input string req, input string what, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // CRC as stated in R4
    function automatic int ref_crc(input int off);
        int taps [8] = '{'hC0C1, 'hC181, 'hC301, 'hC601, 'hCC01, 'hD801, 'hF001, 'hA001};
        int c = 'hFFFF;
        for (int i = 0; i < PAY; i++) begin
            c = c ^ int'(win[off + i]);
            for (int j = 0; j < 8; j++) begin
                int b = c & 1;
                c = c >> 1;
                if (b != 0) c = c ^ (taps[j] << (7 - j));
            end
        end
        return c & 'hFFFF;
    endfunction

    task automatic build_copy(input int cp, input int cnt, input bit good, input int seed);
        int off = cp * 'h100;
        int crc;
        for (int i = 0; i < PAY; i++)
            win[off + i] = 8'((seed * 37 + i * 13 + (i >> 3)) ^ 'hA5);
        win[off + 'h70] = 8'(cnt);
        win[off + 'h71] = 8'(cnt >> 8);
        crc = ref_crc(off);
        if (!good) crc = crc ^ 'h0100;
        win[off + 'h72] = 8'(crc);
        win[off + 'h73] = 8'(crc >> 8);
    endtask

    task automatic setup(input int ptr, input bit g0, input bit g1, input int c0, input int c1, input int seed);
        ptr_v   = 16'(ptr);
        tb_base = ptr << 3;
        for (int i = 0; i < 512; i++) win[i] = 8'(i ^ 'h3C);
        build_copy(0, c0, g0, seed);
        build_copy(1, c1, g1, seed + 1);
    endtask

    task automatic do_run(input int poke_at, input int tail);
        nout = 0; ndone = 0; nrd = 0; last_ok = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k < 3000 && ndone == 0; k++) begin
            start = (k == poke_at);
            @(negedge clk);
        end
        start = 1'b0;
        repeat (tail) @(negedge clk);
    endtask

    task automatic expect_run(input bit exp_ok, input int exp_copy, input int exp_rd, input string req);
        int mism = 0;
        int first_bad = -1;
        chk(ndone == 1, "R9", "done pulses", ndone, 1);
        chk(last_ok == exp_ok, req, "done_ok", int'(last_ok), int'(exp_ok));
        chk(nout == (exp_ok ? PAY : 0), "R8", "byte count", nout, exp_ok ? PAY : 0);
        chk(nrd == exp_rd, "R10", "read count", nrd, exp_rd);
        if (exp_ok && nout == PAY) begin
            for (int i = 0; i < PAY; i++)
                if (got[i] !== win[exp_copy * 'h100 + i]) begin
                    mism++;
                    if (first_bad < 0) first_bad = i;
                end
            chk(mism == 0, exp_copy != 0 ? "R3" : "R8", "payload mismatches (first index)", first_bad, -1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cv [4] = '{0, 1, 'h7FFF, 'hFFFF};
        int seed = 1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy, "R10", "busy at reset", int'(busy), 0);
        chk(!done, "R10", "done at reset", int'(done), 0);
        chk(!mem_rd, "R10", "mem_rd at reset", int'(mem_rd), 0);
        chk(!out_valid, "R10", "out_valid at reset", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: several pointer values, copy 1 newer
        setup('h0040, 1, 1, 5, 6, 3);  do_run(-1, 4); expect_run(1, 1, RD_OK, "R1");
        setup('h1234, 1, 1, 9, 2, 7);  do_run(-1, 4); expect_run(1, 0, RD_OK, "R1");
        // R2: base exactly at the limit is accepted
        setup('h7FC0, 1, 1, 1, 2, 11); do_run(-1, 4); expect_run(1, 1, RD_OK, "R2");
        // R2: base past the limit fails with pointer reads only
        setup('h7FC1, 1, 1, 1, 2, 13); do_run(-1, 4); expect_run(0, 0, 2, "R2");
        setup('hFFFF, 1, 1, 1, 2, 17); do_run(-1, 4); expect_run(0, 0, 2, "R2");

        // R4 R5 R6 R7: validity x count sweep
        for (int v = 0; v < 4; v++) begin
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 4; b++) begin
                    bit g0 = v[0];
                    bit g1 = v[1];
                    bit eok = g0 | g1;
                    int ecp = (g1 && (!g0 || cv[b] > cv[a])) ? 1 : 0;
                    string tag = (g0 && g1) ? "R6" : (eok ? "R7" : "R7");
                    seed = seed + 2;
                    setup('h0100 + v * 'h40 + a, g0, g1, cv[a], cv[b], seed);
                    do_run(-1, 3);
                    expect_run(eok, ecp, eok ? RD_OK : RD_NONE, tag);
                    if (g0 != g1) chk(ndone == 1, "R4", "single-valid CRC verdict done", ndone, 1);
                    if (g0 && g1) chk(last_ok, "R5", "both CRCs accepted", int'(last_ok), 1);
                end
            end
        end

        // R9: start while busy is ignored
        setup('h0100, 1, 1, 3, 3, 99);
        do_run(40, 500);
        expect_run(1, 0, RD_OK, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule